// File: doc/BRIEF.md
# Power Event and SMI Aggregator

This block gathers the interrupt request lines of a set of on-chip peripheral functions and turns them into two system outputs. One is a power-management event (PME) and the other is a system-management interrupt (SMI). Both outputs are active low.

- Every implemented source owns a sticky status flag. The flag is captured on the rising edge of the source's request line.
- Each source has one enable for the PME path and a separate enable for the SMI path.
- A global output enable decides whether PME can be asserted at all.
- The watchdog source does not use the per-source SMI enable. It reaches SMI only through a dedicated control bit.

Host software uses a small register port. The read path is combinational and writes take effect on a single-cycle write strobe. Through this port the host reads the status flags and clears them by writing 1 to them. It also reads and writes the enables.

The 16 request/status bit positions are:

| Bit | Source |
|-----|--------|
| 0 | UART B |
| 1 | UART A |
| 2 | floppy controller |
| 3 | parallel port |
| 5 | MIDI |
| 8 | UART C |
| 9 | UART D |
| 10 | watchdog |
| 11 | smart card |
| 4, 6, 7, 12 to 15 | reserved |

Register addresses:

| Address | Contents | Access |
|---------|----------|--------|
| 0 | status bits 7:0 | write 1 to clear |
| 1 | status bits 15:8 | write 1 to clear |
| 2 | PME enable bits 7:0 | read/write |
| 3 | PME enable bits 15:8 | read/write |
| 4 | SMI enable bits 7:0 | read/write |
| 5 | SMI enable bits 15:8 | read/write |
| 6 | control: bit 0 = PME output enable, bit 1 = watchdog SMI enable | read/write |
| 7 | none | reads zero |

Top module: `pme_smi_agg`

## Requirements
- R1: After reset, every register reads 0x00, and pme_no_o and smi_no_o are both 1.
- R2: A 0-to-1 transition of an implemented req_i bit, sampled at a clock edge, sets the matching status bit at that edge. A request line held high does not set the bit again after it has been cleared.
- R3: A set status bit stays set until the host writes 1 to it at address 0 or 1. Writing 0 to it leaves it set.
- R4: If a rising request and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Reserved bits never set, and they read as zero in every register. This covers request bits 4, 6, 7 and 12 to 15, the reserved bits of each enable register, and control bits 7:2. Address 7 reads 0x00.
- R6: pme_no_o is 0 exactly when the PME output enable is 1 and some status bit is set together with its PME enable bit. It follows the register state with no added cycle.
- R7: smi_no_o is a register output. It is 0 one cycle after some non-watchdog status bit is set together with its SMI enable bit, or after the watchdog status bit (bit 10) is set while the watchdog SMI enable is 1.
- R8: The watchdog reaches SMI only through control bit 1. Bit 10 of the SMI enable (address 5, bit 2) cannot be written and reads 0.
- R9: Reads at addresses 0 to 7 return the contents listed in the register address table.
- R10: The enable and control registers read back the value written, masked to their implemented bits. Writing 0xFF gives 0x2F at address 2, 0x0F at address 3, 0x2F at address 4, 0x0B at address 5 and 0x03 at address 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Source request lines, one per status bit position |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational from addr_i |
| pme_no_o | output | 1 | Power-management event, active low |
| smi_no_o | output | 1 | System-management interrupt, active low, registered |

## Verification
The assertions take for granted that the request lines are synchronous to the clock and change only between edges. They also assume that a write is a one-cycle strobe whose address and data are stable at the sampling edge. Under those assumptions, edge capture and write-1-to-clear can be tracked cycle by cycle. The stimulus drives every input just after the falling edge. It toggles random request bits, including reserved positions. It mixes random writes to all eight addresses with directed cases for a rise that coincides with a clear and for the watchdog's private SMI path.

// File: rtl/pme_smi_pkg.sv
package pme_smi_pkg;
  localparam int DW   = 8;
  localparam int NREG = 2;
  localparam int SW   = DW * NREG;
  localparam int AW   = 3;
  localparam int WDT_BIT = 10;
  localparam logic [SW-1:0] SRC_MASK = 16'h0F2F;
  localparam logic [SW-1:0] SMI_MASK = SRC_MASK & ~(SW'(1) << WDT_BIT);

  typedef enum logic [AW-1:0] {
    A_STS_LO = 3'd0,
    A_STS_HI = 3'd1,
    A_PEN_LO = 3'd2,
    A_PEN_HI = 3'd3,
    A_SEN_LO = 3'd4,
    A_SEN_HI = 3'd5,
    A_CTRL   = 3'd6,
    A_NONE   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/pme_smi_status.sv
module pme_smi_status
  import pme_smi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] req_i,
  input  logic [SW-1:0] clr_i,
  output logic [SW-1:0] sts_o
);
  for (genvar i = 0; i < SW; i++) begin : g_bit
    if (SRC_MASK[i]) begin : g_src
      logic req_q, sts_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          req_q <= 1'b0;
          sts_q <= 1'b0;
        end else begin
          req_q <= req_i[i];
          // a new rise wins over a simultaneous clear
          sts_q <= (req_i[i] & ~req_q) | (sts_q & ~clr_i[i]);
        end
      end
      assign sts_o[i] = sts_q;
    end else begin : g_rsvd
      logic unused_b;
      assign unused_b = req_i[i] ^ clr_i[i];
      assign sts_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/pme_smi_regs.sv
module pme_smi_regs
  import pme_smi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [SW-1:0] sts_i,
  output logic [SW-1:0] clr_o,
  output logic [SW-1:0] pme_en_o,
  output logic [SW-1:0] smi_en_o,
  output logic          pme_oe_o,
  output logic          wdt_smi_en_o,
  output logic [DW-1:0] rdata_o
);
  reg_addr_e     addr;
  logic [SW-1:0] wvec, lane_m;
  logic          wr_sts, wr_pen, wr_sen, wr_ctl;

  assign addr   = reg_addr_e'(addr_i);
  assign wvec   = {NREG{wdata_i}};
  assign lane_m = {{DW{addr_i[0]}}, {DW{~addr_i[0]}}};
  assign wr_sts = wr_i && (addr == A_STS_LO || addr == A_STS_HI);
  assign wr_pen = wr_i && (addr == A_PEN_LO || addr == A_PEN_HI);
  assign wr_sen = wr_i && (addr == A_SEN_LO || addr == A_SEN_HI);
  assign wr_ctl = wr_i && (addr == A_CTRL);

  assign clr_o = wr_sts ? (wvec & lane_m & SRC_MASK) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pme_en_o     <= '0;
      smi_en_o     <= '0;
      pme_oe_o     <= 1'b0;
      wdt_smi_en_o <= 1'b0;
    end else begin
      if (wr_pen) pme_en_o <= (pme_en_o & ~lane_m) | (wvec & lane_m & SRC_MASK);
      if (wr_sen) smi_en_o <= (smi_en_o & ~lane_m) | (wvec & lane_m & SMI_MASK);
      if (wr_ctl) begin
        pme_oe_o     <= wdata_i[0];
        wdt_smi_en_o <= wdata_i[1];
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_STS_LO: rdata_o = sts_i[DW-1:0];
      A_STS_HI: rdata_o = sts_i[SW-1:DW];
      A_PEN_LO: rdata_o = pme_en_o[DW-1:0];
      A_PEN_HI: rdata_o = pme_en_o[SW-1:DW];
      A_SEN_LO: rdata_o = smi_en_o[DW-1:0];
      A_SEN_HI: rdata_o = smi_en_o[SW-1:DW];
      A_CTRL:   rdata_o = {{(DW-2){1'b0}}, wdt_smi_en_o, pme_oe_o};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pme_smi_combine.sv
module pme_smi_combine
  import pme_smi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sts_i,
  input  logic [SW-1:0] pme_en_i,
  input  logic [SW-1:0] smi_en_i,
  input  logic          pme_oe_i,
  input  logic          wdt_smi_en_i,
  output logic          pme_no_o,
  output logic          smi_no_o
);
  logic smi_hit, smi_q;

  assign pme_no_o = ~(pme_oe_i & |(pme_en_i & sts_i));
  assign smi_hit  = |(smi_en_i & SMI_MASK & sts_i) | (wdt_smi_en_i & sts_i[WDT_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_q <= 1'b0;
    else         smi_q <= smi_hit;
  end

  assign smi_no_o = ~smi_q;
endmodule

// File: rtl/pme_smi_agg.sv
module pme_smi_agg
  import pme_smi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          pme_no_o,
  output logic          smi_no_o
);
  logic [SW-1:0] sts, clr, pme_en, smi_en;
  logic          pme_oe, wdt_smi_en;

  pme_smi_status u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req_i),
    .clr_i (clr),
    .sts_o (sts)
  );

  pme_smi_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .sts_i       (sts),
    .clr_o       (clr),
    .pme_en_o    (pme_en),
    .smi_en_o    (smi_en),
    .pme_oe_o    (pme_oe),
    .wdt_smi_en_o(wdt_smi_en),
    .rdata_o     (rdata_o)
  );

  pme_smi_combine u_combine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sts_i       (sts),
    .pme_en_i    (pme_en),
    .smi_en_i    (smi_en),
    .pme_oe_i    (pme_oe),
    .wdt_smi_en_i(wdt_smi_en),
    .pme_no_o    (pme_no_o),
    .smi_no_o    (smi_no_o)
  );
endmodule

// File: rtl/pme_smi_agg_chk.sv
module pme_smi_agg_chk
  import pme_smi_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic [SW-1:0] req_i,
  input logic          wr_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          pme_no_o,
  input logic          smi_no_o,
  input logic [SW-1:0] sts,
  input logic [SW-1:0] smi_en,
  input logic          pme_oe,
  input logic          wdt_smi_en
);
  logic [SW-1:0] req_d, rise, clr_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_d <= '0;
    else         req_d <= req_i;
  end

  assign rise  = req_i & ~req_d & SRC_MASK;
  assign clr_c = (wr_i && addr_i == 3'd0) ? {8'h00, wdata_i} :
                 (wr_i && addr_i == 3'd1) ? {wdata_i, 8'h00} : '0;

  AST_SET_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((sts & $past(rise)) == $past(rise))); // R2
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts & $past(sts & ~clr_c)) == $past(sts & ~clr_c))); // R3
  AST_RSVD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd0) |-> ((rdata_o & 8'hD0) == 8'h00)); // R5
  AST_NONE_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd7) |-> (rdata_o == 8'h00)); // R9
  AST_PME_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pme_oe |-> pme_no_o); // R6
  AST_SMI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts == '0) |=> smi_no_o); // R7
  AST_WDT_SMI_PRIVATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wdt_smi_en && ((sts & smi_en & 16'h0B2F) == '0)) |=> smi_no_o); // R8
endmodule

bind pme_smi_agg pme_smi_agg_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .wr_i      (wr_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pme_no_o  (pme_no_o),
  .smi_no_o  (smi_no_o),
  .sts       (sts),
  .smi_en    (smi_en),
  .pme_oe    (pme_oe),
  .wdt_smi_en(wdt_smi_en)
);

// File: tb/pme_smi_agg_tb.sv
module pme_smi_agg_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0;
  logic        wr_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        pme_no_o, smi_no_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  localparam logic [15:0] M_SRC = 16'h0F2F;
  localparam logic [15:0] M_SMI = 16'h0B2F;

  logic [15:0] m_sts, m_pen, m_sen, m_req;
  logic        m_oe, m_wdt, m_smi;
  logic [15:0] cur_req;

  always #10 clk_i = ~clk_i;

  pme_smi_agg u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .pme_no_o(pme_no_o), .smi_no_o(smi_no_o)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_sts[7:0];
      3'd1: return m_sts[15:8];
      3'd2: return m_pen[7:0];
      3'd3: return m_pen[15:8];
      3'd4: return m_sen[7:0];
      3'd5: return m_sen[15:8];
      3'd6: return {6'd0, m_wdt, m_oe};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic m_pme_n();
    return !(m_oe && ((m_pen & m_sts) != 0));
  endfunction

  function automatic logic m_smi_hit();
    return ((m_sen & M_SMI & m_sts) != 0) || (m_wdt && m_sts[10]);
  endfunction

  // one clock: inputs driven after negedge, outputs sampled at next negedge
  task automatic cyc(input logic w, input logic [2:0] a, input logic [7:0] d);
    logic [15:0] rise, lane, clr;
    req_i = cur_req; wr_i = w; addr_i = a; wdata_i = d;
    #1;
    if (!w) chk("R9 read", {8'h00, rdata_o}, {8'h00, m_rd(a)});
    chk("R6 pme", {15'd0, pme_no_o}, {15'd0, m_pme_n()});
    m_smi = m_smi_hit();
    rise = cur_req & ~m_req & M_SRC;
    m_req = cur_req;
    lane = a[0] ? 16'hFF00 : 16'h00FF;
    clr = (w && a <= 3'd1) ? ({d, d} & lane) : 16'h0;
    m_sts = (m_sts & ~clr) | rise;
    if (w && (a == 3'd2 || a == 3'd3)) m_pen = (m_pen & ~lane) | ({d, d} & lane & M_SRC);
    if (w && (a == 3'd4 || a == 3'd5)) m_sen = (m_sen & ~lane) | ({d, d} & lane & M_SMI);
    if (w && a == 3'd6) begin m_oe = d[0]; m_wdt = d[1]; end
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R7 smi", {15'd0, smi_no_o}, {15'd0, !m_smi});
  endtask

  task automatic idle(); cyc(1'b0, 3'd7, 8'h00); endtask
  task automatic wr(input logic [2:0] a, input logic [7:0] d); cyc(1'b1, a, d); endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [7:0] exp);
    req_i = cur_req; wr_i = 1'b0; addr_i = a;
    #1;
    chk(tag, {8'h00, rdata_o}, {8'h00, exp});
    cyc(1'b0, a, 8'h00);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    m_sts = '0; m_pen = '0; m_sen = '0; m_req = '0;
    m_oe = 1'b0; m_wdt = 1'b0; m_smi = 1'b0; cur_req = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      addr_i = 3'(a); #1;
      chk("R1 reset read", {8'h00, rdata_o}, 16'h0000);
    end
    chk("R1 pme", {15'd0, pme_no_o}, 16'd1);
    chk("R1 smi", {15'd0, smi_no_o}, 16'd1);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 / R8 / R5: enable readback masks
    wr(3'd2, 8'hFF); rd_chk("R10 pen lo", 3'd2, 8'h2F);
    wr(3'd3, 8'hFF); rd_chk("R10 pen hi", 3'd3, 8'h0F);
    wr(3'd4, 8'hFF); rd_chk("R10 sen lo", 3'd4, 8'h2F);
    wr(3'd5, 8'hFF); rd_chk("R8 sen hi wdt bit", 3'd5, 8'h0B);
    wr(3'd6, 8'hFF); rd_chk("R5 ctrl reserved", 3'd6, 8'h03);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00);

    // R2: rise sets, held level does not re-set
    cur_req = 16'h0008; idle();
    rd_chk("R2 rise sets", 3'd0, 8'h08);
    chk("R6 no enable", {15'd0, pme_no_o}, 16'd1);
    wr(3'd0, 8'h08); idle();
    rd_chk("R2 level no reset", 3'd0, 8'h00);
    cur_req = 16'h0; idle(); cur_req = 16'h0008; idle();
    // R3: writing zero keeps it
    wr(3'd0, 8'h00); rd_chk("R3 w0 keeps", 3'd0, 8'h08);
    wr(3'd0, 8'hF7); rd_chk("R3 other bits keep", 3'd0, 8'h08);
    // R4: rise and clear together
    wr(3'd0, 8'h08); cur_req = 16'h0; idle();
    cur_req = 16'h0008; wr(3'd0, 8'h08);
    rd_chk("R4 set wins", 3'd0, 8'h08);
    // R5: reserved requests
    cur_req = 16'hF0D8; idle();
    rd_chk("R5 rsvd lo", 3'd0, 8'h08);
    rd_chk("R5 rsvd hi", 3'd1, 8'h00);
    cur_req = 16'h0; wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); idle();
    rd_chk("R9 none addr", 3'd7, 8'h00);

    // R6: global PME gate
    wr(3'd2, 8'h08); cur_req = 16'h0008; idle();
    chk("R6 gated off", {15'd0, pme_no_o}, 16'd1);
    wr(3'd6, 8'h01);
    chk("R6 asserted", {15'd0, pme_no_o}, 16'd0);
    wr(3'd0, 8'h08);
    chk("R6 released", {15'd0, pme_no_o}, 16'd1);

    // R8: watchdog needs its own enable
    wr(3'd5, 8'hFF); cur_req = 16'h0408; idle(); idle();
    chk("R8 wdt no smi", {15'd0, smi_no_o}, 16'd1);
    wr(3'd6, 8'h03); idle();
    chk("R8 wdt smi", {15'd0, smi_no_o}, 16'd0);
    wr(3'd1, 8'h04); idle();
    chk("R8 wdt cleared", {15'd0, smi_no_o}, 16'd1);
    // R7: one-cycle latency via UART C
    cur_req = 16'h0508; idle();
    chk("R7 not yet", {15'd0, smi_no_o}, 16'd1);
    idle();
    chk("R7 asserted", {15'd0, smi_no_o}, 16'd0);

    // random phase
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      cur_req = cur_req ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
      if (r[1:0] == 2'b00) wr(3'(r[10:8]), 8'(r[23:16]));
      else cyc(1'b0, 3'(r[6:4]), 8'h00);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule